// File: doc/BRIEF.md
# Two-Lane Unfolded Recursive Filter with Nine-Sample Feedback

This block computes the recursion y(n) = a·y(n−9) + x(n) at two samples per clock. Each accepted cycle (one "block", index k) carries the even-indexed sample x(2k) on one lane and the odd-indexed sample x(2k+1) on the other, together with a signed coefficient a. Both outputs y(2k) and y(2k+1) of that block leave the block one clock later. The sample stream and its results match a reference that takes one sample per clock.

Unfolding by two gives two multiply-add lanes, and the nine-sample feedback loop splits into two crossed paths. The odd lane's result is held for 5 blocks and then feeds the even lane. The even lane's result is held for 4 blocks and then feeds the odd lane. The feedback storage is therefore nine words in total, the same as the serial loop. The lag is a parameter. Each lane's delay depth follows the general rule: lane i feeds lane (i+lag) mod 2 through floor((i+lag)/2) block registers.

Top module: `unfolded_fb_iir`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and both outputs are 0. Reset also clears all feedback storage to zero.
- R2: `out_valid` in a cycle equals `in_valid` of the previous cycle. The outputs of block k appear one clock after that block is presented.
- R3: For every accepted block, `y_even` = y(2k) and `y_odd` = y(2k+1) of the serial recursion y(n) = a·y(n−9) + x(n). The coefficient a is the one presented with that block.
- R4: The even lane's feedback term is the odd-lane output from exactly 5 accepted blocks earlier, y(2k−9).
- R5: The odd lane's feedback term is the even-lane output from exactly 4 accepted blocks earlier, y(2k−8).
- R6: After reset the history is zero. The first nine samples of the recursion (blocks 0 to 3 on both lanes, and block 4 on the even lane) equal their inputs whatever the coefficient.
- R7: A cycle with `in_valid` low changes neither the feedback storage nor `y_even`/`y_odd`. Later blocks compute as if the idle cycle never happened.
- R8: Data words are 16-bit two's complement and the coefficient is Q1.14 (value = code/16384). The product y·a is rounded at bit 14 by adding 8192 and then shifting right arithmetically. This rounds half toward +infinity: +0.5 LSB gives 1 and −0.5 LSB gives 0.
- R9: The rounded product is saturated to [−32768, 32767] before the addition, and the sum with x is saturated to the same range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Block present on the lane inputs; feedback advances only when high |
| x_even | input | 16 | Sample x(2k), signed |
| x_odd | input | 16 | Sample x(2k+1), signed |
| coef | input | 16 | Coefficient a, signed Q1.14 |
| out_valid | output | 1 | Registered outputs carry a new block |
| y_even | output | 16 | Result y(2k), signed |
| y_odd | output | 16 | Result y(2k+1), signed |

## Verification
Single impulses placed on the odd lane and on the even lane show whether each crossed path has the right depth and the right destination lane. An echo at the wrong block, or on the wrong lane, fails at once. A directed run right after reset with a large coefficient shows whether the history starts at zero. Crafted ±0.5 LSB products and full-scale operands separate the rounding direction from the two saturation points. Long random runs with random per-block coefficients and scattered idle cycles are compared with a serial golden recursion. They expose any error in lane pairing or coefficient timing, and any idle cycle that disturbs the delay lines.

// File: rtl/uf_iir_pkg.sv
package uf_iir_pkg;

  // Unfolding by two: lane i (0 = even, 1 = odd) feeds lane (i+lag)%2
  // through floor((i+lag)/2) block-rate registers.
  localparam int unsigned LANES = 2;

  function automatic int unsigned fb_dest(input int unsigned lag, input int unsigned lane);
    return (lane + lag) % LANES;
  endfunction

  function automatic int unsigned fb_depth(input int unsigned lag, input int unsigned lane);
    return (lane + lag) / LANES;
  endfunction

endpackage

// File: rtl/uf_mac_lane.sv
// One lane: round(fb * coef) saturated, plus x, saturated.
module uf_mac_lane #(
  parameter int unsigned DW = 16,
  parameter int unsigned CW = 16,
  parameter int unsigned FW = 14
) (
  input  logic signed [DW-1:0] fb,
  input  logic signed [DW-1:0] x,
  input  logic signed [CW-1:0] coef,
  output logic signed [DW-1:0] y
);
  localparam int unsigned PW = DW + CW;
  localparam logic signed [PW:0] RND  = (PW+1)'(64'sd1 <<< (FW-1));
  localparam logic signed [PW:0] MAXV = (PW+1)'((64'sd1 <<< (DW-1)) - 64'sd1);
  localparam logic signed [PW:0] MINV = -(PW+1)'(64'sd1 <<< (DW-1));
  localparam logic signed [DW-1:0] YMAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic signed [DW-1:0] YMIN = {1'b1, {(DW-1){1'b0}}};

  logic signed [PW-1:0] prod;
  logic signed [PW:0]   prod_rnd;
  logic signed [PW:0]   shifted;
  logic signed [DW-1:0] term;
  logic signed [DW:0]   sum;

  always_comb begin
    prod     = $signed({{CW{fb[DW-1]}}, fb}) * $signed({{DW{coef[CW-1]}}, coef});
    prod_rnd = $signed({prod[PW-1], prod}) + RND;
    shifted  = prod_rnd >>> FW;
    if (shifted > MAXV)      term = YMAX;
    else if (shifted < MINV) term = YMIN;
    else                     term = shifted[DW-1:0];
    sum = $signed({term[DW-1], term}) + $signed({x[DW-1], x});
    if (sum[DW] != sum[DW-1]) y = sum[DW] ? YMIN : YMAX;
    else                      y = sum[DW-1:0];
  end
endmodule

// File: rtl/uf_delay_line.sv
// Block-rate delay line; shifts only when en is high.
module uf_delay_line #(
  parameter int unsigned DW    = 16,
  parameter int unsigned DEPTH = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic signed [DW-1:0] d,
  output logic signed [DW-1:0] q
);
  logic signed [DW-1:0] tap_q [DEPTH];
  logic signed [DW-1:0] tap_d [DEPTH];

  always_comb begin
    tap_d = tap_q;
    if (en) begin
      tap_d[0] = d;
      for (int i = 1; i < int'(DEPTH); i++) tap_d[i] = tap_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(DEPTH); i++) tap_q[i] <= '0;
    end else begin
      tap_q <= tap_d;
    end
  end

  assign q = tap_q[DEPTH-1];
endmodule

// File: rtl/unfolded_fb_iir.sv
module unfolded_fb_iir
  import uf_iir_pkg::*;
#(
  parameter int unsigned DW  = 16,
  parameter int unsigned CW  = 16,
  parameter int unsigned FW  = 14,
  parameter int unsigned LAG = 9   // feedback lag in samples; must be >= 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] x_even,
  input  logic signed [DW-1:0] x_odd,
  input  logic signed [CW-1:0] coef,
  output logic                 out_valid,
  output logic signed [DW-1:0] y_even,
  output logic signed [DW-1:0] y_odd
);
  // Reset: asserted asynchronously, released after two clock edges.
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  // Lane datapaths and crossed feedback
  logic signed [DW-1:0] lane_x  [LANES];
  logic signed [DW-1:0] lane_y  [LANES];
  logic signed [DW-1:0] lane_fb [LANES];

  assign lane_x[0] = x_even;
  assign lane_x[1] = x_odd;

  for (genvar gi = 0; gi < int'(LANES); gi++) begin : g_lane
    localparam int unsigned DST   = fb_dest(LAG, gi);
    localparam int unsigned DEPTH = fb_depth(LAG, gi);

    uf_mac_lane #(.DW(DW), .CW(CW), .FW(FW)) u_mac (
      .fb   (lane_fb[gi]),
      .x    (lane_x[gi]),
      .coef (coef),
      .y    (lane_y[gi])
    );

    uf_delay_line #(.DW(DW), .DEPTH(DEPTH)) u_dly (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .en    (in_valid),
      .d     (lane_y[gi]),
      .q     (lane_fb[DST])
    );
  end

  // Output register stage
  logic                 vld_d, vld_q;
  logic signed [DW-1:0] ye_d, ye_q, yo_d, yo_q;

  always_comb begin
    vld_d = in_valid;
    ye_d  = ye_q;
    yo_d  = yo_q;
    if (in_valid) begin
      ye_d = lane_y[0];
      yo_d = lane_y[1];
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vld_q <= 1'b0;
      ye_q  <= '0;
      yo_q  <= '0;
    end else begin
      vld_q <= vld_d;
      ye_q  <= ye_d;
      yo_q  <= yo_d;
    end
  end

  assign out_valid = vld_q;
  assign y_even    = ye_q;
  assign y_odd     = yo_q;
endmodule

// File: rtl/uf_iir_checker.sv
module uf_iir_checker #(
  parameter int unsigned DW = 16,
  parameter int unsigned CW = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 rst_sync_n,
  input logic                 in_valid,
  input logic signed [DW-1:0] x_even,
  input logic signed [DW-1:0] x_odd,
  input logic signed [CW-1:0] coef,
  input logic                 out_valid,
  input logic signed [DW-1:0] y_even,
  input logic signed [DW-1:0] y_odd
);
  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && y_even == '0 && y_odd == '0));

  p_valid_rise_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |=> out_valid);

  p_valid_drop_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> !out_valid);

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> ($stable(y_even) && $stable(y_odd)));

  p_zero_coef_pass_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && coef == '0) |=> (y_even == $past(x_even) && y_odd == $past(x_odd)));
endmodule

bind unfolded_fb_iir uf_iir_checker #(.DW(DW), .CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rst_sync_n (rst_sync_n),
  .in_valid   (in_valid),
  .x_even     (x_even),
  .x_odd      (x_odd),
  .coef       (coef),
  .out_valid  (out_valid),
  .y_even     (y_even),
  .y_odd      (y_odd)
);

// File: tb/unfolded_fb_iir_bench.sv
`timescale 1ns/1ps
module unfolded_fb_iir_bench;
  logic clk = 1'b0;
  logic rst_n;
  logic in_valid;
  logic signed [15:0] x_even, x_odd, coef;
  logic out_valid;
  logic signed [15:0] y_even, y_odd;

  int n_checks = 0;
  int n_err    = 0;
  bit finished = 0;

  int yh [0:2047];
  int n_s = 0;

  always #4 clk = ~clk;  // 125 MHz

  unfolded_fb_iir u_unfolded_fb_iir (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .x_even(x_even), .x_odd(x_odd), .coef(coef),
    .out_valid(out_valid), .y_even(y_even), .y_odd(y_odd)
  );

  function automatic int clamp16(input int v);
    if (v > 32767)  return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  // R8/R9: product rounded half up at bit 14, then saturated
  function automatic int mulq(input int y, input int a);
    int p;
    p = y * a;
    return clamp16((p + 8192) >>> 14);
  endfunction

  function automatic int model_step(input int x, input int a);
    int prev, r;
    prev = (n_s >= 9) ? yh[n_s-9] : 0;
    r = clamp16(mulq(prev, a) + x);
    yh[n_s] = r;
    n_s++;
    return r;
  endfunction

  task automatic chk(input int act, input int exp, input string req);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 1'b0;
    x_even = 16'sd123; x_odd = -16'sd77; coef = 16'sd5000;
    repeat (3) @(negedge clk);
    chk(int'(out_valid), 0, "R1 out_valid in reset");
    chk(int'(y_even), 0, "R1 y_even in reset");
    chk(int'(y_odd), 0, "R1 y_odd in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    n_s = 0;
  endtask

  // Present one block; check against the serial golden recursion (R3).
  task automatic blk(input int xe, input int xo, input int a);
    int ee, eo;
    in_valid = 1'b1;
    x_even = 16'(xe); x_odd = 16'(xo); coef = 16'(a);
    ee = model_step(xe, a);
    eo = model_step(xo, a);
    @(negedge clk);
    chk(int'(out_valid), 1, "R2 out_valid after block");
    chk(int'(y_even), ee, "R3 y_even vs serial recursion");
    chk(int'(y_odd), eo, "R3 y_odd vs serial recursion");
  endtask

  task automatic idle();
    int pe, po;
    pe = int'(y_even); po = int'(y_odd);
    in_valid = 1'b0;
    x_even = 16'($urandom); x_odd = 16'($urandom); coef = 16'($urandom);
    @(negedge clk);
    chk(int'(out_valid), 0, "R2 out_valid after idle");
    chk(int'(y_even), pe, "R7 y_even held on idle");
    chk(int'(y_odd), po, "R7 y_odd held on idle");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int xs [10];
    void'($urandom(32'h5EED_2024));
    do_reset();

    // R6: zero history, large coefficient
    for (int i = 0; i < 10; i++) xs[i] = int'($urandom_range(65535)) - 32768;
    for (int b = 0; b < 4; b++) begin
      blk(xs[2*b], xs[2*b+1], 15000);
      chk(int'(y_even), xs[2*b], "R6 even equals input");
      chk(int'(y_odd), xs[2*b+1], "R6 odd equals input");
    end
    blk(xs[8], xs[9], 15000);
    chk(int'(y_even), xs[8], "R6 ninth sample equals input");

    // R4/R5: odd impulse, a = 0.5
    do_reset();
    blk(0, 1000, 8192);
    for (int b = 1; b < 15; b++) begin
      blk(0, 0, 8192);
      if (b == 5)  chk(int'(y_even), 500, "R4 odd->even after 5 blocks");
      if (b == 9)  chk(int'(y_odd), 250, "R5 even->odd after 4 blocks");
      if (b == 14) chk(int'(y_even), 125, "R4 second odd->even echo");
      if (b == 4)  chk(int'(y_odd), 0, "R5 no early odd echo");
    end

    // R5: even impulse
    do_reset();
    blk(1000, 0, 8192);
    for (int b = 1; b < 6; b++) begin
      blk(0, 0, 8192);
      if (b == 4) chk(int'(y_odd), 500, "R5 even->odd after 4 blocks");
      if (b == 4) chk(int'(y_even), 0, "R4 no even echo on even lane");
    end

    // R8: +/-0.5 LSB rounding with a = 1/16384
    do_reset();
    blk(-8192, 8192, 1);
    for (int b = 1; b < 6; b++) blk(0, 0, 1);
    chk(int'(y_even), 1, "R8 +0.5 rounds up");
    // y(9) (block4 odd) was -0.5 -> 0; check via golden record
    chk(yh[9], 0, "R8 -0.5 rounds to zero (model)");

    // R9: product saturation, a = -1.0, y = -32768
    do_reset();
    blk(0, -32768, -16384);
    for (int b = 1; b < 5; b++) blk(0, 0, -16384);
    blk(100, 0, -16384);
    chk(int'(y_even), 32767, "R9 product and sum saturate high");

    // R9: sum saturation low, a = 1.0
    do_reset();
    blk(0, -30000, 16384);
    for (int b = 1; b < 5; b++) blk(0, 0, 16384);
    blk(-10000, 0, 16384);
    chk(int'(y_even), -32768, "R9 sum saturates low");

    // R3/R7: random blocks, random coefficients, idle gaps
    do_reset();
    for (int b = 0; b < 400; b++) begin
      blk(int'($urandom_range(65535)) - 32768, int'($urandom_range(65535)) - 32768,
          int'($urandom_range(32767)) - 16384);
      if ($urandom_range(6) == 0) idle();
    end

    // R3: zero coefficient passes input through
    blk(4321, -1234, 0);
    chk(int'(y_even), 4321, "R3 zero coefficient even");
    chk(int'(y_odd), -1234, "R3 zero coefficient odd");

    in_valid = 1'b0;
    @(negedge clk);
    summary();
  end
endmodule